// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Event Counter

This block holds two 16-bit counters. Each one steps either on an internal machine tick, which is the clock divided by `TICK_DIV`, or on falling edges of its own count pin, sampled once per tick. A run bit starts and stops each counter. An optional gate pin lets a counter measure how long that pin stays high. Each counter takes one of four modes:

- a prescaled mode, where the low bits of the low byte form a prescaler that feeds the high byte;
- a full 16-bit mode;
- an 8-bit mode that reloads itself from the high byte;
- a split mode, which makes counter 0 into two independent 8-bit counters.

An overflow sets a sticky flag. Every overflow of counter 1 also sends a one-clock pulse to the serial rate logic.

Software drives the block through a byte-wide write port. The port sets the configuration, the run bits, the flag-clear bits and the four count bytes. The counts and flags are visible directly on the outputs.

Top module: `tick_counter_pair`

## Requirements
- R1: After reset, both counts are 0, both flags are 0 and `baudTick` is 0.
- R2: A write loads a register according to `wrAddr`:
  - address 0 is the configuration byte: bits [1:0] are the counter 0 mode, bit 2 selects the count pin for counter 0, bit 3 enables the gate for counter 0, bits [5:4] are the counter 1 mode, bit 6 selects the count pin for counter 1 and bit 7 enables the gate for counter 1;
  - address 1 is control: bit 0 is run0 and bit 1 is run1;
  - addresses 2 and 3 are the low and high bytes of counter 0;
  - addresses 4 and 5 are the low and high bytes of counter 1;
  - addresses 6 and 7 have no effect.

  A byte load takes priority over counting in the same cycle.
- R3: With the internal source selected, an enabled counter steps once every `TICK_DIV` clocks.
- R4: With the pin source selected, a counter steps once for each 1-to-0 change of its count pin, as seen between two successive ticks.
- R5: A counter is enabled when its run bit is 1 and either its gate enable is 0 or its gate pin is 1.
- R6: Mode 0 (prescaled):
  - bits [4:0] of the low byte count, and their wrap from 31 increments the high byte;
  - the flag is set when the high byte wraps from FF;
  - bits [7:5] of the low byte never change by counting.
- R7: Mode 1 counts over the full 16 bits and sets the flag on the wrap from FFFF to 0.
- R8: Mode 2 counts in the low byte. On the wrap from FF, the low byte takes the high-byte value and the flag is set.
- R9: Mode 3 on counter 0:
  - the low byte is an 8-bit counter under counter 0's source, gate and run controls, and it sets flag0;
  - the high byte counts internal ticks while run1 is 1, and it sets flag1.
- R10: Counter 1 in mode 3 holds its value.
- R11: While counter 0 is in mode 3, an overflow of counter 1 never sets flag1.
- R12: Each overflow of counter 1 gives `baudTick` high for exactly one clock, the clock after the counting edge, whatever the mode of counter 0.
- R13: Flags are sticky. Writing 1 to control bit 2 clears flag0, and writing 1 to control bit 3 clears flag1. An overflow in the same cycle as the clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | CNT_W/2 | Write data byte |
| countPin | input | 2 | External count inputs, bit i for counter i |
| gatePin | input | 2 | Gate inputs, bit i for counter i |
| count0 | output | CNT_W | Counter 0 value |
| count1 | output | CNT_W | Counter 1 value |
| flag0 | output | 1 | Overflow flag 0 |
| flag1 | output | 1 | Overflow flag 1 (also set by the split high half) |
| baudTick | output | 1 | One-clock pulse on each counter 1 overflow |

## Verification
The bench builds the block with `TICK_DIV` = 3 and leaves the width and the prescaler at their defaults. The short tick lets a mode 0 prescaled overflow, mode 2 reloads, split-mode overflows of both halves and a run of counter 1 overflows, each feeding `baudTick`, all happen within a few hundred clocks. Preloaded counts put every wrap close at hand. A tick length of three clocks also leaves room to hold the count pin low for exactly two ticks, so each falling edge is counted exactly once.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  typedef enum logic [1:0] {
    MODE_PRE    = 2'd0,
    MODE_FULL   = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tcMode_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic step0;    // counter 0 (or its low half in split mode) advances
    logic step0Hi;  // split high half advances
    logic step1;    // counter 1 advances
    logic ld0Lo;
    logic ld0Hi;
    logic ld1Lo;
    logic ld1Hi;
    logic clr0;
    logic clr1;
  } tcStrobe_t;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_CTL  = 3'd1;
  localparam logic [2:0] A_C0LO = 3'd2;
  localparam logic [2:0] A_C0HI = 3'd3;
  localparam logic [2:0] A_C1LO = 3'd4;
  localparam logic [2:0] A_C1HI = 3'd5;

endpackage

// File: rtl/tcp_ctrl.sv
module tcp_ctrl
  import tcp_pkg::*;
#(
  parameter int TICK_DIV = 12,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        countPin,
  input  logic [1:0]        gatePin,
  output tcStrobe_t         strobe,
  output tcMode_e           mode0,
  output tcMode_e           mode1
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
  localparam logic [DW-1:0] DIV_ONE  = DW'(1);

  logic [DATA_W-1:0] cfgReg;
  logic [1:0]        run;
  logic [DW-1:0]     divCnt;
  logic              tick;
  logic [1:0]        pinLast;
  logic [1:0]        extSel, gateEn, go;

  // machine tick divider
  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + DIV_ONE;
  end

  // configuration and run registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      run    <= '0;
    end else if (wrEn) begin
      if (wrAddr == A_CFG) cfgReg <= wrData;
      if (wrAddr == A_CTL) run    <= wrData[1:0];
    end
  end

  // count pin sample, one per tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinLast <= '0;
    else if (tick) pinLast <= countPin;
  end

  assign mode0  = tcMode_e'(cfgReg[1:0]);
  assign mode1  = tcMode_e'(cfgReg[5:4]);
  assign extSel = {cfgReg[6], cfgReg[2]};
  assign gateEn = {cfgReg[7], cfgReg[3]};

  for (genvar i = 0; i < 2; i++) begin : g_src
    logic srcEvt, enabled;
    assign srcEvt  = extSel[i] ? (pinLast[i] & ~countPin[i]) : 1'b1;
    assign enabled = run[i] & (~gateEn[i] | gatePin[i]);
    assign go[i]   = tick & srcEvt & enabled;
  end

  always_comb begin
    strobe         = '0;
    strobe.step0   = go[0];
    strobe.step1   = go[1] & (mode1 != MODE_SPLIT);
    strobe.step0Hi = tick & run[1] & (mode0 == MODE_SPLIT);
    strobe.ld0Lo   = wrEn & (wrAddr == A_C0LO);
    strobe.ld0Hi   = wrEn & (wrAddr == A_C0HI);
    strobe.ld1Lo   = wrEn & (wrAddr == A_C1LO);
    strobe.ld1Hi   = wrEn & (wrAddr == A_C1HI);
    strobe.clr0    = wrEn & (wrAddr == A_CTL) & wrData[2];
    strobe.clr1    = wrEn & (wrAddr == A_CTL) & wrData[3];
  end

  // R3: ticks are never on adjacent clocks
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R2: control write loads the run bits
  p_run_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_CTL) |=> (run == $past(wrData[1:0])));

endmodule

// File: rtl/tcp_datapath.sv
module tcp_datapath
  import tcp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  tcStrobe_t          strobe,
  input  tcMode_e            mode0,
  input  tcMode_e            mode1,
  input  logic [CNT_W/2-1:0] wrData,
  output logic [CNT_W-1:0]   count0,
  output logic [CNT_W-1:0]   count1,
  output logic               flag0,
  output logic               flag1,
  output logic               baudTick
);
  localparam int HALF = CNT_W / 2;
  localparam logic [HALF-1:0]  ONE_H = HALF'(1);
  localparam logic [CNT_W-1:0] ONE_W = CNT_W'(1);
  localparam logic [PRE_W-1:0] ONE_P = PRE_W'(1);

  // returns {overflow, next value}
  function automatic logic [CNT_W:0] advance(tcMode_e m, logic [CNT_W-1:0] c);
    logic [HALF-1:0] lo, hi;
    logic [CNT_W:0]  r;
    lo = c[HALF-1:0];
    hi = c[CNT_W-1:HALF];
    case (m)
      MODE_PRE:
        if (&lo[PRE_W-1:0]) r = {&hi, hi + ONE_H, lo[HALF-1:PRE_W], {PRE_W{1'b0}}};
        else                r = {1'b0, hi, lo[HALF-1:PRE_W], lo[PRE_W-1:0] + ONE_P};
      MODE_FULL:   r = {&c, c + ONE_W};
      MODE_RELOAD:
        if (&lo) r = {1'b1, hi, hi};
        else     r = {1'b0, hi, lo + ONE_H};
      default:     r = {&lo, hi, lo + ONE_H};
    endcase
    return r;
  endfunction

  logic [CNT_W:0]   res0, res1;
  logic [CNT_W-1:0] next0, next1;
  logic             ovf0, ovf1, hiOvf;

  always_comb begin
    res0  = advance(mode0, count0);
    ovf0  = strobe.step0 & res0[CNT_W];
    next0 = strobe.step0 ? res0[CNT_W-1:0] : count0;
    hiOvf = 1'b0;
    if (mode0 == MODE_SPLIT && strobe.step0Hi) begin
      next0[CNT_W-1:HALF] = count0[CNT_W-1:HALF] + ONE_H;
      hiOvf               = &count0[CNT_W-1:HALF];
    end
    if (strobe.ld0Lo) next0[HALF-1:0]     = wrData;
    if (strobe.ld0Hi) next0[CNT_W-1:HALF] = wrData;

    res1  = advance(mode1, count1);
    ovf1  = strobe.step1 & res1[CNT_W];
    next1 = strobe.step1 ? res1[CNT_W-1:0] : count1;
    if (strobe.ld1Lo) next1[HALF-1:0]     = wrData;
    if (strobe.ld1Hi) next1[CNT_W-1:HALF] = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count0   <= '0;
      count1   <= '0;
      flag0    <= 1'b0;
      flag1    <= 1'b0;
      baudTick <= 1'b0;
    end else begin
      count0   <= next0;
      count1   <= next1;
      flag0    <= (flag0 & ~strobe.clr0) | ovf0;
      flag1    <= (flag1 & ~strobe.clr1) | hiOvf | (ovf1 & (mode0 != MODE_SPLIT));
      baudTick <= ovf1;
    end
  end

  // R10: counter 1 in split mode holds unless written
  p_split_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode1 == MODE_SPLIT && !strobe.ld1Lo && !strobe.ld1Hi) |=> $stable(count1));

  // R13: flag stays set until cleared
  p_flag_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    (flag0 && !strobe.clr0) |=> flag0);

  // R8: low byte reloads from the high byte on wrap
  p_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode0 == MODE_RELOAD && strobe.step0 && (&count0[HALF-1:0]) &&
     !strobe.ld0Lo && !strobe.ld0Hi)
    |=> (count0[HALF-1:0] == $past(count0[CNT_W-1:HALF])));

  // R6: upper low-byte bits untouched by prescaled counting
  p_pre_bits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode0 == MODE_PRE && !strobe.ld0Lo)
    |=> (count0[HALF-1:PRE_W] == $past(count0[HALF-1:PRE_W])));

  // R12: rate pulse lasts one clock
  p_baud_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

endmodule

// File: rtl/tick_counter_pair.sv
module tick_counter_pair
  import tcp_pkg::*;
#(
  parameter int TICK_DIV = 12,
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [CNT_W/2-1:0] wrData,
  input  logic [1:0]         countPin,
  input  logic [1:0]         gatePin,
  output logic [CNT_W-1:0]   count0,
  output logic [CNT_W-1:0]   count1,
  output logic               flag0,
  output logic               flag1,
  output logic               baudTick
);
  tcStrobe_t strobe;
  tcMode_e   mode0, mode1;

  tcp_ctrl #(.TICK_DIV(TICK_DIV), .DATA_W(CNT_W/2)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .countPin(countPin), .gatePin(gatePin),
    .strobe(strobe), .mode0(mode0), .mode1(mode1)
  );

  tcp_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode0(mode0), .mode1(mode1),
    .wrData(wrData), .count0(count0), .count1(count1),
    .flag0(flag0), .flag1(flag1), .baudTick(baudTick)
  );

endmodule

// File: tb/tick_counter_pair_test.sv
`timescale 1ns/1ps
module tick_counter_pair_test;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  countPin = '0;
  logic [1:0]  gatePin = '0;
  logic [15:0] count0, count1;
  logic        flag0, flag1, baudTick;

  tick_counter_pair #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .countPin(countPin), .gatePin(gatePin), .count0(count0), .count1(count1),
    .flag0(flag0), .flag1(flag1), .baudTick(baudTick)
  );

  always #5 clk = ~clk;

  int    nChk = 0, nFail = 0, baudSeen = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  int mDiv, mCfg, mRun, mPin0, mPin1, mC0, mC1, mF0, mF1, mBaud;

  task automatic modelStep(input int mode, input int c, output int n, output int ovf);
    int lo, hi, pre, mid;
    lo = c % 256; hi = c / 256; ovf = 0;
    case (mode)
      0: begin
        pre = c % 32; mid = (c / 32) % 8;
        if (pre == 31) begin pre = 0; ovf = (hi == 255); hi = (hi + 1) % 256; end
        else pre = pre + 1;
        n = hi * 256 + mid * 32 + pre;
      end
      1: begin ovf = (c == 65535); n = (c + 1) % 65536; end
      2: begin
        if (lo == 255) begin ovf = 1; lo = hi; end else lo = lo + 1;
        n = hi * 256 + lo;
      end
      default: begin ovf = (lo == 255); n = hi * 256 + (lo + 1) % 256; end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mCfg = 0; mRun = 0; mPin0 = 0; mPin1 = 0;
      mC0 = 0; mC1 = 0; mF0 = 0; mF1 = 0; mBaud = 0;
    end else begin
      int tk, md0, md1, go0, go1, n0, n1, ovf0, ovf1, ovfHi, h, e0, e1;
      tk  = (mDiv == DIV - 1);
      md0 = mCfg % 4; md1 = (mCfg / 16) % 4;
      e0 = ((mCfg >> 2) & 1) ? (mPin0 && !countPin[0]) : 1;
      e1 = ((mCfg >> 6) & 1) ? (mPin1 && !countPin[1]) : 1;
      go0 = tk && e0 && (mRun & 1) && (!((mCfg >> 3) & 1) || gatePin[0]);
      go1 = tk && e1 && ((mRun >> 1) & 1) && (!((mCfg >> 7) & 1) || gatePin[1]);
      n0 = mC0; n1 = mC1; ovf0 = 0; ovf1 = 0; ovfHi = 0;
      if (go0) modelStep(md0, mC0, n0, ovf0);
      if (md0 == 3 && tk && ((mRun >> 1) & 1)) begin
        h = n0 / 256; ovfHi = (h == 255);
        n0 = ((h + 1) % 256) * 256 + n0 % 256;
      end
      if (go1 && md1 != 3) modelStep(md1, mC1, n1, ovf1);
      if (wrEn) begin
        case (wrAddr)
          2: n0 = (n0 / 256) * 256 + wrData;
          3: n0 = wrData * 256 + n0 % 256;
          4: n1 = (n1 / 256) * 256 + wrData;
          5: n1 = wrData * 256 + n1 % 256;
          default: ;
        endcase
        if (wrAddr == 1 && wrData[2]) mF0 = 0;
        if (wrAddr == 1 && wrData[3]) mF1 = 0;
      end
      if (ovf0) mF0 = 1;
      if (ovfHi || (ovf1 && md0 != 3)) mF1 = 1;
      mBaud = ovf1;
      mC0 = n0; mC1 = n1;
      if (tk) begin mPin0 = countPin[0]; mPin1 = countPin[1]; end
      mDiv = tk ? 0 : mDiv + 1;
      if (wrEn && wrAddr == 0) mCfg = wrData;
      if (wrEn && wrAddr == 1) mRun = wrData & 3;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      nChk++;
      if (count0 !== mC0[15:0] || count1 !== mC1[15:0] || flag0 !== mF0[0] ||
          flag1 !== mF1[0] || baudTick !== mBaud[0]) begin
        nFail++;
        $display("FAIL %s: act c0=%h c1=%h f=%b%b b=%b exp c0=%h c1=%h f=%0d%0d b=%0d",
                 curReq, count0, count1, flag1, flag0, baudTick,
                 mC0[15:0], mC1[15:0], mF1, mF0, mBaud);
      end
      if (baudTick) baudSeen++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "count0", count0, 0);
    chk("R1", "count1", count1, 0);
    chk("R1", "flags", {flag1, flag0}, 0);
    chk("R1", "baudTick", baudTick, 0);

    // R2 loads, unused addresses
    curReq = "R2";
    wr(0, 8'h11); wr(2, 8'h34); wr(3, 8'h12);
    wr(6, 8'hFF); wr(7, 8'hFF);
    idle(20);
    chk("R2", "count0 load", count0, 16'h1234);
    chk("R2", "count1 untouched", count1, 0);

    // R7 full wrap
    curReq = "R7";
    wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h01);
    idle(80);
    chk("R7", "flag0 after wrap", flag0, 1);

    // R3 exact rate: 30 counting edges = 10 ticks
    curReq = "R3";
    wr(1, 8'h00); c = count0;
    wr(1, 8'h01); idle(28); wr(1, 8'h00);
    chk("R3", "steps in window", int'(count0 - c), 10);

    // R13 clear
    curReq = "R13";
    wr(1, 8'h04);
    chk("R13", "flag0 cleared", flag0, 0);

    // R5 gate
    curReq = "R5";
    wr(0, 8'h19); gatePin = 2'b00; wr(1, 8'h01); c = count0;
    idle(40);
    chk("R5", "gated low holds", count0, c);
    gatePin = 2'b01; idle(30);
    chk("R5", "gate high counts", int'(count0 > c), 1);
    wr(1, 8'h00); gatePin = 2'b00;

    // R4 external falling edges
    curReq = "R4";
    wr(0, 8'h15); countPin = 2'b01; wr(1, 8'h01);
    idle(12); c = count0;
    for (int k = 0; k < 10; k++) begin
      countPin[0] = 1'b0; idle(6);
      countPin[0] = 1'b1; idle(6);
    end
    idle(6);
    chk("R4", "edges counted", int'(count0 - c), 10);
    wr(1, 8'h00);

    // R6 prescaled mode
    curReq = "R6";
    wr(1, 8'h0C); wr(0, 8'h10); wr(2, 8'hE0); wr(3, 8'hFE); wr(1, 8'h01);
    idle(300);
    chk("R6", "flag0", flag0, 1);
    chk("R6", "low bits 7:5", count0[7:5], 7);
    wr(1, 8'h00);

    // R8 reload
    curReq = "R8";
    wr(1, 8'h0C); wr(0, 8'h12); wr(2, 8'hFA); wr(3, 8'hF0); wr(1, 8'h01);
    idle(60);
    chk("R8", "flag0", flag0, 1);
    chk("R8", "high byte kept", count0[15:8], 8'hF0);
    chk("R8", "low from reload", int'(count0[7:0] >= 8'hF0), 1);
    wr(1, 8'h00);

    // R9 split
    curReq = "R9";
    wr(1, 8'h0C); wr(0, 8'h13); wr(2, 8'hF8); wr(3, 8'hFC);
    wr(4, 8'h00); wr(5, 8'h00); wr(1, 8'h03);
    idle(60);
    chk("R9", "flag0 low half", flag0, 1);
    chk("R9", "flag1 high half", flag1, 1);
    wr(1, 8'h00);

    // R11 counter 1 cannot flag while split
    curReq = "R11";
    wr(1, 8'h0C); wr(0, 8'h23); wr(3, 8'h00); wr(4, 8'hFE); wr(5, 8'hFE);
    baudSeen = 0; wr(1, 8'h02);
    idle(60); wr(1, 8'h00);
    chk("R11", "flag1 stays low", flag1, 0);
    chk("R12", "baud pulses while split", int'(baudSeen >= 5), 1);

    // R10 counter 1 held in mode 3
    curReq = "R10";
    wr(0, 8'h33); c = count1; baudSeen = 0; wr(1, 8'h02);
    idle(40);
    chk("R10", "count1 held", count1, c);
    chk("R10", "no baud pulses", baudSeen, 0);
    wr(1, 8'h00);

    // R12 normal flagging and pulses
    curReq = "R12";
    wr(1, 8'h0C); wr(0, 8'h21); wr(4, 8'hFE); wr(5, 8'hFE);
    baudSeen = 0; wr(1, 8'h02);
    idle(30); wr(1, 8'h00);
    chk("R12", "flag1 set", flag1, 1);
    chk("R12", "baud pulses", int'(baudSeen >= 3), 1);

    // R13 repeated clears racing overflows (reference decides)
    curReq = "R13";
    wr(1, 8'h02);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); wrEn = 1'b1; wrAddr = 3'd1; wrData = 8'h0A;
    end
    @(negedge clk); wrEn = 1'b0;
    idle(10);
    wr(1, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule